// File: doc/BRIEF.md
# Parallel Flash Command Sequencer (Host Side)

This block sits on the host side of an asynchronous 16-bit parallel flash. It accepts one command at a time over a valid/ready handshake: word program, sector erase, chip erase, or identifier read. It turns that command into the exact train of unlock and command bus writes, using write-enable-controlled timing. It then watches for completion by reading the array over and over. Every flash timing minimum is given in nanoseconds and converted to whole clock cycles, always rounding up.

The polling loop has two modes. In toggle mode it reads one fixed address until two back-to-back reads agree on data bit 6. In data-poll mode it reads until bit 7 matches the expected value: the bit-7 of the programmed word, or 1 after an erase. Between reads the output enable goes high for a minimum gap. A cycle-count watchdog ends a poll that does not complete and reports an error instead. The result (done or error, plus data) stays on the response port until the host acknowledges it.

Top module: `pflash_cmd_seq`

## Requirements
- R1: With a 10 ns clock and default timings, every write-enable low pulse lasts exactly 9 cycles. Write-enable stays high at least 9 cycles between pulses of one command. The address is stable at least 1 cycle before write-enable falls.
- R2: During every write pulse, chip enable is low, output enable is high, the data bus is driven, and address and data do not change.
- R3: Command codes on cmd_op_i are 0 program, 1 sector erase, 2 chip erase, 3 identifier read. Each code produces a fixed write sequence, given as address/low-byte pairs with upper data byte 0. Program: 5555/AA, 2AAA/55, 5555/A0, then the target word at cmd_addr_i. Sector erase: 5555/AA, 2AAA/55, 5555/80, 5555/AA, 2AAA/55, then cmd_addr_i/30. Chip erase: the same as sector erase, except the last write is 5555/10.
- R4: An identifier read writes 5555/AA, 2AAA/55, 5555/90. It then reads address 0 and address 1, and writes 5555/F0. The response data is {low byte of read 1, low byte of read 0}, and the error flag is 0.
- R5: Each poll or identifier read holds output enable high for at least 15 cycles beforehand and low for exactly 12 cycles. The bus is not driven during a read. Poll reads all use cmd_addr_i.
- R6: In toggle mode (cmd_poll_i = 0), completion is the first read whose bit 6 equals bit 6 of the read just before it. The response data is that read.
- R7: In data-poll mode (cmd_poll_i = 1), completion is the first read whose bit 7 equals the expected bit. The expected bit is bit 7 of cmd_data_i for a program and 1 for an erase.
- R8: If POLL_LIMIT cycles have passed since the command was accepted when a poll read finishes, and that read did not complete the poll, the response reports error = 1.
- R9: cmd_ready_o is high only when no command is running and no response is pending. A command presented while ready is low is ignored. The response stays valid, with the same error flag and data, until rsp_ack_i.
- R10: After reset, chip, write and output enables are high, the bus is not driven, ready is 1 and no response is valid.
- R11: Write enable and output enable are never low together, and chip enable is high whenever no command is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| cmd_valid_i | input | 1 | command request |
| cmd_ready_o | output | 1 | command accepted when high with valid |
| cmd_op_i | input | 2 | command code (R3) |
| cmd_addr_i | input | AW | target word or sector address |
| cmd_data_i | input | 16 | word to program |
| cmd_poll_i | input | 1 | 0 toggle polling, 1 data polling |
| rsp_valid_o | output | 1 | result pending |
| rsp_err_o | output | 1 | poll timed out |
| rsp_data_o | output | 16 | last poll word or identifier bytes |
| rsp_ack_i | input | 1 | clears the pending result |
| flash_ce_no | output | 1 | chip enable, active low |
| flash_we_no | output | 1 | write enable, active low |
| flash_oe_no | output | 1 | output enable, active low |
| flash_addr_o | output | AW | flash address |
| flash_dq_o | output | 16 | write data |
| flash_dq_oe_o | output | 1 | drive enable for write data |
| flash_dq_i | input | 16 | read data |

## Verification
The assertions assume two things about the inputs. First, rsp_ack_i is only meaningful while a response is pending. Second, the flash read data is steady from the falling output enable until the sample point. The bench's flash model changes its data only on that falling edge, and it acknowledges only after it has seen rsp_valid_o. The sweeps cover every erase and program code in both poll modes, with a range of busy-read counts and program words chosen so that the completion read falls both one and two reads after busy ends. Separate runs cover the identifier read, a timeout in each mode, and a command pushed while the block is busy.

// File: rtl/pflash_pkg.sv
package pflash_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_ID   = 2'd3
  } op_e;

  localparam logic [14:0] UNLK_A1 = 15'h5555;
  localparam logic [14:0] UNLK_A2 = 15'h2AAA;
  localparam logic [7:0]  K_UNLK1 = 8'hAA;
  localparam logic [7:0]  K_UNLK2 = 8'h55;
  localparam logic [7:0]  K_PROG  = 8'hA0;
  localparam logic [7:0]  K_ERSU  = 8'h80;
  localparam logic [7:0]  K_SECT  = 8'h30;
  localparam logic [7:0]  K_CHIP  = 8'h10;
  localparam logic [7:0]  K_IDEN  = 8'h90;
  localparam logic [7:0]  K_IDEX  = 8'hF0;

  function automatic int ns_to_cyc(int ns, int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [2:0] seq_len(op_e op);
    case (op)
      OP_PROG: return 3'd4;
      OP_ID:   return 3'd3;
      default: return 3'd6;
    endcase
  endfunction
endpackage

// File: rtl/pflash_step_dec.sv
module pflash_step_dec
  import pflash_pkg::*;
#(
  parameter int AW = 18
) (
  input  op_e             op_i,
  input  logic [2:0]      idx_i,
  input  logic            exit_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [15:0]     data_i,
  output logic [AW-1:0]   a_o,
  output logic [15:0]     d_o
);
  localparam logic [AW-1:0] A1 = AW'(UNLK_A1);
  localparam logic [AW-1:0] A2 = AW'(UNLK_A2);

  always_comb begin
    a_o = A1;
    d_o = {8'h00, K_UNLK1};
    if (exit_i) begin
      d_o = {8'h00, K_IDEX};
    end else begin
      case (idx_i)
        3'd0, 3'd3: begin
          if (op_i == OP_PROG && idx_i == 3'd3) begin
            a_o = addr_i;
            d_o = data_i;
          end
        end
        3'd1, 3'd4: begin
          a_o = A2;
          d_o = {8'h00, K_UNLK2};
        end
        3'd2: begin
          case (op_i)
            OP_PROG: d_o = {8'h00, K_PROG};
            OP_ID:   d_o = {8'h00, K_IDEN};
            default: d_o = {8'h00, K_ERSU};
          endcase
        end
        default: begin
          if (op_i == OP_SECT) begin
            a_o = addr_i;
            d_o = {8'h00, K_SECT};
          end else begin
            d_o = {8'h00, K_CHIP};
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pflash_bus_phy.sv
module pflash_bus_phy
  import pflash_pkg::*;
#(
  parameter int AW     = 18,
  parameter int N_AS   = 1,
  parameter int N_LOW  = 9,
  parameter int N_HOLD = 9,
  parameter int N_OEH  = 15,
  parameter int N_RD   = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [15:0]   wdata_i,
  output logic          done_o,
  output logic [15:0]   rdata_o,
  output logic          we_no,
  output logic          oe_no,
  output logic [AW-1:0] addr_o,
  output logic [15:0]   dq_o,
  output logic          dq_oe_o,
  input  logic [15:0]   dq_i
);
  localparam int NMAX = imax(imax(imax(N_AS, N_LOW), imax(N_HOLD, N_OEH)), N_RD);
  localparam int CW   = $clog2(NMAX + 1);

  typedef enum logic [2:0] {P_IDLE, P_WSU, P_WLO, P_WHD, P_RGAP, P_RLO} pst_e;

  pst_e          st;
  logic [CW-1:0] cnt;
  logic          last;

  assign last = (cnt == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= P_IDLE;
      cnt     <= '0;
      we_no   <= 1'b1;
      oe_no   <= 1'b1;
      addr_o  <= '0;
      dq_o    <= '0;
      dq_oe_o <= 1'b0;
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (st != P_IDLE) cnt <= cnt - CW'(1);
      case (st)
        P_IDLE: if (go_i) begin
          addr_o <= addr_i;
          if (wr_i) begin
            dq_o    <= wdata_i;
            dq_oe_o <= 1'b1;
            cnt     <= CW'(N_AS);
            st      <= P_WSU;
          end else begin
            cnt <= CW'(N_OEH);
            st  <= P_RGAP;
          end
        end
        P_WSU: if (last) begin
          we_no <= 1'b0;
          cnt   <= CW'(N_LOW);
          st    <= P_WLO;
        end
        P_WLO: if (last) begin
          we_no <= 1'b1;
          cnt   <= CW'(N_HOLD);
          st    <= P_WHD;
        end
        P_WHD: if (last) begin
          dq_oe_o <= 1'b0;
          done_o  <= 1'b1;
          st      <= P_IDLE;
        end
        P_RGAP: if (last) begin
          oe_no <= 1'b0;
          cnt   <= CW'(N_RD);
          st    <= P_RLO;
        end
        P_RLO: if (last) begin
          rdata_o <= dq_i;
          oe_no   <= 1'b1;
          done_o  <= 1'b1;
          st      <= P_IDLE;
        end
        default: st <= P_IDLE;
      endcase
    end
  end

  // R2
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_no && $past(!we_no)) |-> ($stable(addr_o) && $stable(dq_o)));
  // R2
  wr_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> dq_oe_o);
  // R5
  rd_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_no |-> !dq_oe_o);
  // R5
  rd_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_no && $past(!oe_no)) |-> $stable(addr_o));
endmodule

// File: rtl/pflash_poll_chk.sv
module pflash_poll_chk #(
  parameter int LIMIT = 1000000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        sample_i,
  input  logic        mode_i,
  input  logic        exp_b7_i,
  input  logic [15:0] rdata_i,
  output logic        hit_o,
  output logic        tmo_o
);
  localparam int TW = $clog2(LIMIT + 1);

  logic          have_prev;
  logic          prev_b6;
  logic          active;
  logic [TW-1:0] cnt;

  assign hit_o = mode_i ? (rdata_i[7] == exp_b7_i)
                        : (have_prev && (rdata_i[6] == prev_b6));
  assign tmo_o = (cnt >= TW'(LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_prev <= 1'b0;
      prev_b6   <= 1'b0;
      active    <= 1'b0;
      cnt       <= '0;
    end else if (start_i) begin
      have_prev <= 1'b0;
      active    <= 1'b1;
      cnt       <= '0;
    end else begin
      if (active && !tmo_o) cnt <= cnt + TW'(1);
      if (sample_i) begin
        have_prev <= 1'b1;
        prev_b6   <= rdata_i[6];
        if (hit_o || tmo_o) active <= 1'b0;
      end
    end
  end

  // R8
  tmo_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_o && !start_i) |=> tmo_o);
  // R6
  prev_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(have_prev) |-> $past(sample_i));
endmodule

// File: rtl/pflash_cmd_seq.sv
module pflash_cmd_seq
  import pflash_pkg::*;
#(
  parameter int AW         = 18,
  parameter int CLK_NS     = 10,
  parameter int T_AS_NS    = 10,
  parameter int T_AH_NS    = 50,
  parameter int T_WP_NS    = 90,
  parameter int T_WPH_NS   = 90,
  parameter int T_DS_NS    = 50,
  parameter int T_DH_NS    = 10,
  parameter int T_OEH_NS   = 150,
  parameter int T_ACC_NS   = 120,
  parameter int T_OE_NS    = 50,
  parameter int POLL_LIMIT = 1000000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic [1:0]    cmd_op_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [15:0]   cmd_data_i,
  input  logic          cmd_poll_i,
  output logic          rsp_valid_o,
  output logic          rsp_err_o,
  output logic [15:0]   rsp_data_o,
  input  logic          rsp_ack_i,
  output logic          flash_ce_no,
  output logic          flash_we_no,
  output logic          flash_oe_no,
  output logic [AW-1:0] flash_addr_o,
  output logic [15:0]   flash_dq_o,
  output logic          flash_dq_oe_o,
  input  logic [15:0]   flash_dq_i
);
  localparam int N_AS   = ns_to_cyc(T_AS_NS, CLK_NS);
  localparam int N_LOW  = imax(imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DS_NS, CLK_NS)),
                               ns_to_cyc(T_AH_NS, CLK_NS));
  localparam int N_HOLD = imax(ns_to_cyc(T_WPH_NS, CLK_NS), ns_to_cyc(T_DH_NS, CLK_NS));
  localparam int N_OEH  = ns_to_cyc(T_OEH_NS, CLK_NS);
  localparam int N_RD   = imax(ns_to_cyc(T_ACC_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS));

  typedef enum logic [2:0] {S_IDLE, S_WR, S_POLL, S_IDRD, S_IDEX, S_RSP} st_e;

  st_e           st;
  logic          pend;
  logic [2:0]    idx;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [15:0]   data_q;
  logic          mode_q;
  logic          accept;

  logic          phy_go, phy_wr, phy_done;
  logic [AW-1:0] phy_addr, step_a;
  logic [15:0]   step_d, phy_rdata;
  logic          poll_hit, poll_tmo, poll_sample;

  assign cmd_ready_o = (st == S_IDLE);
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign phy_go      = (st == S_WR || st == S_POLL || st == S_IDRD || st == S_IDEX) && !pend;
  assign phy_wr      = (st == S_WR || st == S_IDEX);
  assign poll_sample = phy_done && (st == S_POLL);

  always_comb begin
    case (st)
      S_POLL:  phy_addr = addr_q;
      S_IDRD:  phy_addr = AW'(idx[0]);
      default: phy_addr = step_a;
    endcase
  end

  pflash_step_dec #(.AW(AW)) u_step (
    .op_i   (op_q),
    .idx_i  (idx),
    .exit_i (st == S_IDEX),
    .addr_i (addr_q),
    .data_i (data_q),
    .a_o    (step_a),
    .d_o    (step_d)
  );

  pflash_bus_phy #(
    .AW(AW), .N_AS(N_AS), .N_LOW(N_LOW), .N_HOLD(N_HOLD), .N_OEH(N_OEH), .N_RD(N_RD)
  ) u_phy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (phy_go),
    .wr_i    (phy_wr),
    .addr_i  (phy_addr),
    .wdata_i (step_d),
    .done_o  (phy_done),
    .rdata_o (phy_rdata),
    .we_no   (flash_we_no),
    .oe_no   (flash_oe_no),
    .addr_o  (flash_addr_o),
    .dq_o    (flash_dq_o),
    .dq_oe_o (flash_dq_oe_o),
    .dq_i    (flash_dq_i)
  );

  pflash_poll_chk #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .sample_i (poll_sample),
    .mode_i   (mode_q),
    .exp_b7_i ((op_q == OP_PROG) ? data_q[7] : 1'b1),
    .rdata_i  (phy_rdata),
    .hit_o    (poll_hit),
    .tmo_o    (poll_tmo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st          <= S_IDLE;
      pend        <= 1'b0;
      idx         <= '0;
      op_q        <= OP_PROG;
      addr_q      <= '0;
      data_q      <= '0;
      mode_q      <= 1'b0;
      flash_ce_no <= 1'b1;
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      if (phy_go) pend <= 1'b1;
      case (st)
        S_IDLE: if (accept) begin
          op_q        <= op_e'(cmd_op_i);
          addr_q      <= cmd_addr_i;
          data_q      <= cmd_data_i;
          mode_q      <= cmd_poll_i;
          idx         <= '0;
          pend        <= 1'b0;
          flash_ce_no <= 1'b0;
          st          <= S_WR;
        end
        S_WR: if (phy_done) begin
          pend <= 1'b0;
          if (idx == seq_len(op_q) - 3'd1) begin
            idx <= '0;
            st  <= (op_q == OP_ID) ? S_IDRD : S_POLL;
          end else begin
            idx <= idx + 3'd1;
          end
        end
        S_POLL: if (phy_done) begin
          pend <= 1'b0;
          if (poll_hit || poll_tmo) begin
            rsp_err_o   <= !poll_hit;
            rsp_data_o  <= phy_rdata;
            rsp_valid_o <= 1'b1;
            flash_ce_no <= 1'b1;
            st          <= S_RSP;
          end
        end
        S_IDRD: if (phy_done) begin
          pend <= 1'b0;
          if (!idx[0]) begin
            rsp_data_o[7:0] <= phy_rdata[7:0];
            idx             <= 3'd1;
          end else begin
            rsp_data_o[15:8] <= phy_rdata[7:0];
            idx              <= '0;
            st               <= S_IDEX;
          end
        end
        S_IDEX: if (phy_done) begin
          pend        <= 1'b0;
          rsp_err_o   <= 1'b0;
          rsp_valid_o <= 1'b1;
          flash_ce_no <= 1'b1;
          st          <= S_RSP;
        end
        S_RSP: if (rsp_ack_i) begin
          rsp_valid_o <= 1'b0;
          st          <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11
  we_oe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!flash_we_no && !flash_oe_no));
  // R2
  we_needs_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flash_we_no |-> !flash_ce_no);
  // R11
  idle_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> (flash_ce_no && flash_we_no && flash_oe_no));
  // R9
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ack_i) |=> (rsp_valid_o && $stable(rsp_err_o) && $stable(rsp_data_o)));
  // R9
  ready_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !cmd_ready_o);
  // R9
  cmd_ign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !cmd_ready_o) |=> ($stable(addr_q) && $stable(data_q)));
endmodule

// File: tb/pflash_cmd_seq_tb_top.sv
module pflash_cmd_seq_tb_top;
  localparam int CLK_NS = 10;
  localparam int AW     = 18;
  localparam int LIMIT  = 3000;
  localparam logic [7:0] MFR = 8'h3C;
  localparam logic [7:0] DEV = 8'hA5;
  localparam logic [AW-1:0] U1 = 18'h05555;
  localparam logic [AW-1:0] U2 = 18'h02AAA;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic          cmd_valid = 1'b0, cmd_ready, cmd_poll = 1'b0;
  logic [1:0]    cmd_op = 2'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic [15:0]   cmd_data = '0;
  logic          rsp_valid, rsp_err, rsp_ack = 1'b0;
  logic [15:0]   rsp_data;
  logic          ce_n, we_n, oe_n, dq_oe;
  logic [AW-1:0] faddr;
  logic [15:0]   dq_o, dq_i = '0;

  pflash_cmd_seq #(.AW(AW), .CLK_NS(CLK_NS), .POLL_LIMIT(LIMIT)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data), .cmd_poll_i(cmd_poll),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_data_o(rsp_data), .rsp_ack_i(rsp_ack),
    .flash_ce_no(ce_n), .flash_we_no(we_n), .flash_oe_no(oe_n),
    .flash_addr_o(faddr), .flash_dq_o(dq_o), .flash_dq_oe_o(dq_oe), .flash_dq_i(dq_i)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // flash model and bus monitors
  int wr_n, rd_n, busy_b, raddr_bad, drv_bad;
  logic [AW-1:0] wa [16];
  logic [15:0]   wd [16];
  logic [AW-1:0] a_lat, poll_addr, a_prev;
  logic [15:0]   fin_d;
  bit exp7, id_mode, seen;
  int we_lo, lo_min, lo_max, we_hi, gap_min, ast, ast_min;
  int oe_hi, oe_gap_min, oe_lo, oe_lo_min;

  always @(negedge we_n) a_lat = faddr;
  always @(posedge we_n) if (rst_ni) begin
    if (wr_n < 16) begin wa[wr_n] = a_lat; wd[wr_n] = dq_o; end
    if (!dq_oe || ce_n || !oe_n) drv_bad++;
    wr_n++;
  end
  always @(negedge oe_n) if (rst_ni) begin
    rd_n++;
    if (faddr !== (id_mode ? AW'(rd_n - 1) : poll_addr)) raddr_bad++;
    if (id_mode) dq_i = {8'h00, (rd_n == 1) ? MFR : DEV};
    else if (rd_n <= busy_b) begin
      dq_i = 16'h0000;
      dq_i[7] = ~exp7;
      dq_i[6] = rd_n[0];
    end else dq_i = fin_d;
  end

  always @(negedge clk) if (rst_ni) begin
    if (faddr === a_prev) ast++; else ast = 0;
    a_prev = faddr;
    if (!we_n) begin
      if (we_lo == 0) begin
        if (seen && we_hi < gap_min) gap_min = we_hi;
        if (ast < ast_min) ast_min = ast;
      end
      we_lo++;
    end else begin
      if (we_lo > 0) begin
        if (we_lo < lo_min) lo_min = we_lo;
        if (we_lo > lo_max) lo_max = we_lo;
        seen = 1'b1;
        we_hi = 0;
      end
      we_lo = 0;
      we_hi++;
    end
    if (!oe_n) begin
      if (oe_lo == 0 && oe_hi < oe_gap_min) oe_gap_min = oe_hi;
      oe_lo++;
    end else begin
      if (oe_lo > 0) begin
        if (oe_lo < oe_lo_min) oe_lo_min = oe_lo;
        oe_hi = 0;
      end
      oe_lo = 0;
      if (!ce_n) oe_hi++;
    end
  end

  function automatic int nwr(input logic [1:0] op);
    return (op == 2'd1 || op == 2'd2) ? 6 : 4;
  endfunction

  function automatic logic [AW-1:0] ea(input logic [1:0] op, input int i, input logic [AW-1:0] a);
    if (op == 2'd3) return (i == 1) ? U2 : U1;
    case (i)
      1, 4: return U2;
      3: return (op == 2'd0) ? a : U1;
      5: return (op == 2'd1) ? a : U1;
      default: return U1;
    endcase
  endfunction

  function automatic logic [15:0] ed(input logic [1:0] op, input int i, input logic [15:0] d);
    case (i)
      0: return 16'h00AA;
      1: return 16'h0055;
      2: return (op == 2'd0) ? 16'h00A0 : (op == 2'd3) ? 16'h0090 : 16'h0080;
      3: return (op == 2'd0) ? d : (op == 2'd3) ? 16'h00F0 : 16'h00AA;
      4: return 16'h0055;
      default: return (op == 2'd1) ? 16'h0030 : 16'h0010;
    endcase
  endfunction

  function automatic int exp_reads(input bit mode, input int b, input bit fd6);
    if (mode) return b + 1;
    if (b == 0) return 2;
    return ((b % 2) == int'(fd6)) ? b + 1 : b + 2;
  endfunction

  int got_cyc;

  task automatic run(input logic [1:0] op, input logic [AW-1:0] a, input logic [15:0] d,
                     input bit mode, input int busy, input bit poke);
    @(negedge clk);
    wr_n = 0; rd_n = 0; raddr_bad = 0; drv_bad = 0; seen = 1'b0;
    we_lo = 0; we_hi = 0; lo_min = 1000000; lo_max = 0; gap_min = 1000000; ast = 0; ast_min = 1000000;
    oe_hi = 0; oe_lo = 0; oe_gap_min = 1000000; oe_lo_min = 1000000;
    busy_b = busy; poll_addr = a; id_mode = (op == 2'd3);
    fin_d = (op == 2'd0) ? d : 16'hFFFF;
    exp7 = (op == 2'd0) ? d[7] : 1'b1;
    chk(cmd_ready == 1'b1, "R9", "ready before cmd", cmd_ready, 1);
    cmd_op = op; cmd_addr = a; cmd_data = d; cmd_poll = mode; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R9", "ready while busy", cmd_ready, 0);
    got_cyc = 1;
    while (!rsp_valid && got_cyc < 40000) begin
      @(negedge clk);
      got_cyc++;
      if (poke && got_cyc == 4) begin
        cmd_op = 2'd2; cmd_addr = 18'h3FFFF; cmd_data = 16'h0000; cmd_valid = 1'b1;
      end else cmd_valid = 1'b0;
    end
    cmd_valid = 1'b0;
  endtask

  task automatic finish_rsp(input bit exp_err, input logic [15:0] exp_d);
    logic e0;
    logic [15:0] d0;
    e0 = rsp_err; d0 = rsp_data;
    chk(rsp_valid == 1'b1, "R9", "response arrived", rsp_valid, 1);
    repeat (4) @(negedge clk);
    chk(rsp_valid && rsp_err == e0 && rsp_data == d0, "R9", "response held", {rsp_valid, rsp_data}, {1'b1, d0});
    chk(cmd_ready == 1'b0, "R9", "no ready while pending", cmd_ready, 0);
    chk(rsp_err == exp_err, exp_err ? "R8" : "R6", "error flag", rsp_err, exp_err);
    if (!exp_err) chk(rsp_data == exp_d, "R7", "result data", rsp_data, exp_d);
    rsp_ack = 1'b1;
    @(negedge clk);
    rsp_ack = 1'b0;
    chk(rsp_valid == 1'b0 && cmd_ready == 1'b1, "R9", "ack clears", {rsp_valid, cmd_ready}, 2'b01);
    chk(ce_n == 1'b1, "R11", "ce high after op", ce_n, 1);
  endtask

  task automatic check_bus(input logic [1:0] op, input logic [AW-1:0] a, input logic [15:0] d);
    bit ok;
    ok = (wr_n == nwr(op));
    for (int i = 0; i < nwr(op) && i < 16; i++)
      if (wa[i] !== ea(op, i, a) || wd[i] !== ed(op, i, d)) ok = 1'b0;
    chk(ok, "R3", "write sequence", wr_n, nwr(op));
    chk(lo_min == 9 && lo_max == 9, "R1", "we low width", lo_min, 9);
    chk(gap_min >= 9, "R1", "we high gap", gap_min, 9);
    chk(ast_min >= 1, "R1", "address setup", ast_min, 1);
    chk(drv_bad == 0, "R2", "write pulse framing", drv_bad, 0);
    chk(oe_gap_min >= 15, "R5", "oe high gap", oe_gap_min, 15);
    chk(oe_lo_min == 12, "R5", "oe low width", oe_lo_min, 12);
    chk(raddr_bad == 0, "R5", "read address", raddr_bad, 0);
  endtask

  initial begin
    logic [15:0] pd [3];
    pd[0] = 16'h1234; pd[1] = 16'h00C3; pd[2] = 16'h5A40;
    repeat (3) @(negedge clk);
    chk(ce_n && we_n && oe_n && !dq_oe, "R10", "bus idle in reset", {ce_n, we_n, oe_n, dq_oe}, 4'b1110);
    chk(cmd_ready && !rsp_valid, "R10", "handshake in reset", {cmd_ready, rsp_valid}, 2'b10);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(ce_n && we_n && oe_n && !dq_oe && cmd_ready && !rsp_valid, "R10", "after reset",
        {ce_n, we_n, oe_n, dq_oe, cmd_ready, rsp_valid}, 6'b111010);

    for (int op = 0; op < 3; op++)
      for (int m = 0; m < 2; m++)
        for (int bi = 0; bi < 4; bi++)
          for (int di = 0; di < ((op == 0) ? 3 : 1); di++) begin
            int b;
            logic [15:0] dd, fd;
            logic [AW-1:0] aa;
            b  = (bi == 3) ? 5 : bi;
            dd = pd[di];
            aa = AW'(18'h03000 + op * 18'h02000 + bi * 7 + di);
            fd = (op == 0) ? dd : 16'hFFFF;
            run(2'(op), aa, dd, m[0], b, 1'b0);
            check_bus(2'(op), aa, dd);
            chk(rd_n == exp_reads(m[0], b, fd[6]), m ? "R7" : "R6", "poll read count",
                rd_n, exp_reads(m[0], b, fd[6]));
            finish_rsp(1'b0, fd);
          end

    // R4 identifier read
    run(2'd3, 18'h12345, 16'h0000, 1'b0, 0, 1'b0);
    check_bus(2'd3, 18'h12345, 16'h0000);
    chk(rd_n == 2, "R4", "id read count", rd_n, 2);
    finish_rsp(1'b0, {DEV, MFR});

    // R8 timeout in both modes
    for (int m = 0; m < 2; m++) begin
      run(2'd1, 18'h05000, 16'h0000, m[0], 1000000, 1'b0);
      chk(got_cyc >= LIMIT, "R8", "timeout not early", got_cyc, LIMIT);
      chk(got_cyc < LIMIT + 100, "R8", "timeout bounded", got_cyc, LIMIT);
      finish_rsp(1'b1, 16'h0000);
    end

    // R9 command while busy is ignored
    run(2'd0, 18'h00777, 16'h0F0F, 1'b1, 2, 1'b1);
    check_bus(2'd0, 18'h00777, 16'h0F0F);
    finish_rsp(1'b0, 16'h0F0F);
    begin
      int w0;
      bit ce_ok;
      w0 = wr_n; ce_ok = 1'b1;
      repeat (40) begin @(negedge clk); if (!ce_n) ce_ok = 1'b0; end
      chk(ce_ok && wr_n == w0, "R9", "busy command not run", wr_n, w0);
      chk(ce_ok, "R11", "ce stays high idle", ce_ok, 1);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_NS * 190000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule